// File: doc/BRIEF.md
# Fine-Adjustable Nanosecond Time Counter

This block keeps a 64-bit nanosecond time of day that is derived from a free-running 32-bit cycle counter running on the block's own clock. Each counter tick is worth a fixed-point rate with a 28-bit fraction. The nominal rate is one tick period, selectable as 8 ns or 10 ns by a parameter. The time is formed as a stored base plus the elapsed cycles times the rate. The elapsed count is taken modulo 2^32, so the wrap of the cycle counter is harmless. The sub-nanosecond remainder is kept between updates, so the time never drifts from the exact sum of the per-tick rates.

A clock servo outside the block trims the rate with a signed frequency request in scaled parts per million. The block converts that request into a multiplier correction in hardware, clamps it to a fixed ceiling, and folds the time accrued at the old rate into the base before the new rate starts. This keeps the time continuous across the change. Two other single-cycle requests, a signed offset and an absolute load, step or set the time. An internal fold at a parameterised interval bounds the elapsed count well inside the counter's wrap period.

Top module: `ns_time_counter`

## Requirements
- R1: While reset is held, `timeNs` reads 0 and `cycleCount` reads the parameter `CYCLE_RESET`. The rate starts at the nominal value `TICK_NS << 28`.
- R2: `cycleCount` increases by one on every rising clock edge after reset and wraps from 2^32-1 to 0.
- R3: With no request, after every edge `timeNs` equals the integer part of (time × 2^28 + sum of the rate over all edges since the last load or reset) divided by 2^28. No fraction is lost over hundreds of edges at a trimmed rate.
- R4: `timeNs` keeps advancing without a jump when `cycleCount` wraps through zero.
- R5: `adjScaledPpm` is in units of 2^-16 ppm, two's complement. A request sampled with `adjValid` high at edge e sets the rate to the nominal value plus trunc(|request| × TICK_NS × 4096 / 10^6). For 8 ns this is |request| × 512 / 15625. The increment at edge e still uses the old rate, and every increment from edge e+1 uses the new one. A request of 0 restores the nominal rate.
- R6: A negative request subtracts the same truncated correction from the nominal rate instead of adding it.
- R7: The magnitude of a request is clamped to 65,536,000 (1,000,000 ppb) before scaling. This holds at both the most positive and the most negative 32-bit values.
- R8: A rate change does not step the time. Time accrued at the old rate is folded in first, including when an offset arrives on the edge that applies the new rate.
- R9: An offset sampled with `offsetValid` high at an edge adds the signed 64-bit `offsetNs` to the time, on top of that edge's normal increment. The fraction is unchanged.
- R10: A load sampled with `loadValid` high at an edge makes `timeNs` equal `loadNs` right after that edge and clears the fraction. Counting resumes from the next edge. Time wraps modulo 2^64.
- R11: When requests coincide on one edge, only one is taken: a load discards an offset and an adjust, and an offset discards an adjust.
- R12: An internal fold happens at least every `FOLD_INTERVAL` edges. It never changes `timeNs`, and the elapsed cycle count it bounds never exceeds `FOLD_INTERVAL`.
- R13: With `TICK_NS` = 10 the nominal rate is 10 << 28 and the correction is |request| × 128 / 3125. The same clamp and timing rules apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| adjValid | input | 1 | One-cycle frequency trim request |
| adjScaledPpm | input | 32 | Signed trim in 2^-16 ppm units |
| offsetValid | input | 1 | One-cycle time step request |
| offsetNs | input | 64 | Signed nanosecond step |
| loadValid | input | 1 | One-cycle time set request |
| loadNs | input | 64 | Nanosecond value to load |
| timeNs | output | 64 | Current time in nanoseconds |
| cycleCount | output | 32 | Raw free-running cycle count |

## Verification
Both outputs are decoded from registers, so the effect of any edge is visible at once. A load or offset shows in `timeNs` right after the edge that samples it. A trim changes the increment one edge later, because the scaled multiplier is registered before it is applied. The driver steps a reference accumulator per edge from the requirements, applying a pending rate first, and queues the expected time and count at the falling edge before that rising edge. The monitor pops and compares 2 ns after the rising edge, so every comparison falls in the cycle where the register outputs have settled. A second instance with a 10 ns tick receives the same stimulus and is checked against its own reference.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  localparam int unsigned CYC_W  = 32;
  localparam int unsigned FRAC_W = 28;
  localparam int unsigned MULT_W = 32;
  localparam int unsigned TIME_W = 64;
  localparam int unsigned PPM_W  = 32;
  localparam longint unsigned PPM_UNITS = 65536;
  localparam longint unsigned PPM_DEN   = 1000000;

  // Strobes issued by the control to the datapath, all valid for one cycle.
  typedef struct packed {
    logic load;
    logic offset;
    logic rate;
    logic fold;
  } ntcStrobe_t;

  function automatic logic [MULT_W-1:0] nominalMult(int unsigned tickNs);
    return MULT_W'(longint'(tickNs) << FRAC_W);
  endfunction

  // ceiling on the scaled-ppm magnitude for a limit given in ppb
  function automatic longint unsigned maxScaled(int unsigned maxPpb);
    return longint'(maxPpb) * PPM_UNITS / 1000;
  endfunction

  // rate correction = scaled * tick * 2^28 / (1e6 * 2^16) = scaled * tick * 4096 / 1e6
  function automatic longint unsigned corrNum(int unsigned tickNs);
    return longint'(tickNs) * 4096;
  endfunction
endpackage

// File: rtl/ntc_rate_scale.sv
module ntc_rate_scale
  import ntc_pkg::*;
#(
  parameter int unsigned TICK_NS     = 8,
  parameter int unsigned MAX_ADJ_PPB = 1000000
) (
  input  logic signed [PPM_W-1:0]  scaledPpm,
  output logic        [MULT_W-1:0] multOut
);
  localparam logic [MULT_W-1:0] NOM     = nominalMult(TICK_NS);
  localparam longint unsigned   MAX_MAG = maxScaled(MAX_ADJ_PPB);
  localparam longint unsigned   NUM     = corrNum(TICK_NS);

  logic [63:0]       wide;
  logic [63:0]       mag;
  logic [63:0]       magClamp;
  logic [63:0]       scaledProd;
  logic [MULT_W-1:0] corr;

  always_comb begin
    wide       = {{(64-PPM_W){scaledPpm[PPM_W-1]}}, scaledPpm};
    mag        = wide[63] ? (~wide + 64'd1) : wide;
    magClamp   = (mag > 64'(MAX_MAG)) ? 64'(MAX_MAG) : mag;
    scaledProd = magClamp * 64'(NUM);
    corr       = MULT_W'(scaledProd / 64'(PPM_DEN));
    multOut    = wide[63] ? (NOM - corr) : (NOM + corr);
  end
endmodule

// File: rtl/ntc_ctrl.sv
module ntc_ctrl
  import ntc_pkg::*;
#(
  parameter int unsigned TICK_NS       = 8,
  parameter int unsigned MAX_ADJ_PPB   = 1000000,
  parameter int unsigned FOLD_INTERVAL = 1 << 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    adjValid,
  input  logic signed [PPM_W-1:0] adjScaledPpm,
  input  logic                    offsetValid,
  input  logic                    loadValid,
  output ntcStrobe_t              strobe,
  output logic [MULT_W-1:0]       pendingMult
);
  localparam int unsigned       FOLD_W    = $clog2(FOLD_INTERVAL + 1);
  localparam logic [FOLD_W-1:0] FOLD_LAST = FOLD_W'(FOLD_INTERVAL - 1);
  localparam logic [MULT_W-1:0] NOM       = nominalMult(TICK_NS);
  localparam logic [MULT_W-1:0] MAX_CORR  =
    MULT_W'(maxScaled(MAX_ADJ_PPB) * corrNum(TICK_NS) / PPM_DEN);

  logic [MULT_W-1:0] scaledMult;
  logic              adjTake;
  logic              rateReg;
  logic [FOLD_W-1:0] sinceFold;
  logic              anyEvent;

  ntc_rate_scale #(
    .TICK_NS    (TICK_NS),
    .MAX_ADJ_PPB(MAX_ADJ_PPB)
  ) u_scale (
    .scaledPpm(adjScaledPpm),
    .multOut  (scaledMult)
  );

  // priority: load, then offset, then rate change
  assign adjTake       = adjValid & ~loadValid & ~offsetValid;
  assign strobe.load   = loadValid;
  assign strobe.offset = offsetValid & ~loadValid;
  assign strobe.rate   = rateReg;
  assign strobe.fold   = (sinceFold == FOLD_LAST);
  assign anyEvent      = strobe.load | strobe.offset | strobe.rate | strobe.fold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateReg     <= 1'b0;
      pendingMult <= NOM;
      sinceFold   <= '0;
    end else begin
      rateReg <= adjTake;
      if (adjTake) pendingMult <= scaledMult;
      sinceFold <= anyEvent ? '0 : sinceFold + FOLD_W'(1);
    end
  end

  AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rate |-> (pendingMult >= NOM - MAX_CORR) && (pendingMult <= NOM + MAX_CORR)); // R7

  AST_PRIO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid || offsetValid) |=> !strobe.rate); // R11
endmodule

// File: rtl/ntc_datapath.sv
module ntc_datapath
  import ntc_pkg::*;
#(
  parameter int unsigned       TICK_NS       = 8,
  parameter logic [CYC_W-1:0]  CYCLE_RESET   = '0,
  parameter int unsigned       FOLD_INTERVAL = 1 << 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ntcStrobe_t        strobe,
  input  logic [MULT_W-1:0] newMult,
  input  logic [TIME_W-1:0] offsetNs,
  input  logic [TIME_W-1:0] loadNs,
  output logic [TIME_W-1:0] timeNs,
  output logic [CYC_W-1:0]  cycleCount
);
  localparam logic [MULT_W-1:0] NOM    = nominalMult(TICK_NS);
  localparam int unsigned       PROD_W = CYC_W + MULT_W + 1;

  logic [CYC_W-1:0]        cycleCnt;
  logic [CYC_W-1:0]        lastCycle;
  logic [TIME_W-1:0]       baseNs;
  logic [FRAC_W-1:0]       frac;
  logic [MULT_W-1:0]       mult;
  logic [CYC_W-1:0]        elapsed;
  logic [PROD_W-1:0]       prodFull;
  logic [PROD_W-FRAC_W-1:0] carryNs;
  logic [TIME_W-1:0]       liveNs;
  logic [TIME_W-1:0]       stepLo;
  logic                    foldAny;

  always_comb begin
    elapsed  = cycleCnt - lastCycle;  // modulo 2^32, safe across wrap
    prodFull = PROD_W'(elapsed) * PROD_W'(mult) + PROD_W'(frac);
    carryNs  = prodFull[PROD_W-1:FRAC_W];
    liveNs   = baseNs + TIME_W'(carryNs);
    stepLo   = TIME_W'(mult[MULT_W-1:FRAC_W]);
    foldAny  = strobe.offset | strobe.rate | strobe.fold;
  end

  assign timeNs     = liveNs;
  assign cycleCount = cycleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt  <= CYCLE_RESET;
      lastCycle <= CYCLE_RESET;
      baseNs    <= '0;
      frac      <= '0;
      mult      <= NOM;
    end else begin
      cycleCnt <= cycleCnt + CYC_W'(1);
      if (strobe.load) begin
        baseNs    <= loadNs;
        frac      <= '0;
        lastCycle <= cycleCnt + CYC_W'(1);
      end else if (foldAny) begin
        baseNs    <= liveNs + (strobe.offset ? offsetNs : '0);
        frac      <= prodFull[FRAC_W-1:0];
        lastCycle <= cycleCnt;
      end
      if (strobe.rate) mult <= newMult;
    end
  end

  AST_ELAPSED_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    elapsed <= CYC_W'(FOLD_INTERVAL)); // R12

  AST_STEADY_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.offset && !strobe.rate) |=>
      ((timeNs - $past(timeNs)) == stepLo) || ((timeNs - $past(timeNs)) == stepLo + 64'd1)); // R3

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.offset && !strobe.rate) |=>
      ((timeNs - $past(timeNs) - $past(offsetNs)) == stepLo) ||
      ((timeNs - $past(timeNs) - $past(offsetNs)) == stepLo + 64'd1)); // R9

  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> timeNs == $past(loadNs)); // R10
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
  import ntc_pkg::*;
#(
  parameter int unsigned      TICK_NS       = 8,
  parameter logic [CYC_W-1:0] CYCLE_RESET   = '0,
  parameter int unsigned      FOLD_INTERVAL = 1 << 24,
  parameter int unsigned      MAX_ADJ_PPB   = 1000000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    adjValid,
  input  logic signed [PPM_W-1:0] adjScaledPpm,
  input  logic                    offsetValid,
  input  logic [TIME_W-1:0]       offsetNs,
  input  logic                    loadValid,
  input  logic [TIME_W-1:0]       loadNs,
  output logic [TIME_W-1:0]       timeNs,
  output logic [CYC_W-1:0]        cycleCount
);
  ntcStrobe_t        strobe;
  logic [MULT_W-1:0] pendingMult;

  ntc_ctrl #(
    .TICK_NS      (TICK_NS),
    .MAX_ADJ_PPB  (MAX_ADJ_PPB),
    .FOLD_INTERVAL(FOLD_INTERVAL)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .adjValid    (adjValid),
    .adjScaledPpm(adjScaledPpm),
    .offsetValid (offsetValid),
    .loadValid   (loadValid),
    .strobe      (strobe),
    .pendingMult (pendingMult)
  );

  ntc_datapath #(
    .TICK_NS      (TICK_NS),
    .CYCLE_RESET  (CYCLE_RESET),
    .FOLD_INTERVAL(FOLD_INTERVAL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .newMult   (pendingMult),
    .offsetNs  (offsetNs),
    .loadNs    (loadNs),
    .timeNs    (timeNs),
    .cycleCount(cycleCount)
  );
endmodule

// File: tb/ns_time_counter_tb.sv
module ns_time_counter_tb;
  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               adjValid = 1'b0;
  logic signed [31:0] adjScaledPpm = '0;
  logic               offsetValid = 1'b0;
  logic [63:0]        offsetNs = '0;
  logic               loadValid = 1'b0;
  logic [63:0]        loadNs = '0;
  logic [63:0]        timeA, timeB;
  logic [31:0]        cycA, cycB;

  localparam logic [31:0] RESET_A = 32'hFFFF_FF00;

  always #2.5 clk = ~clk;  // 200 MHz

  ns_time_counter #(.TICK_NS(8), .CYCLE_RESET(RESET_A), .FOLD_INTERVAL(37)) u_dut (
    .clk(clk), .rstN(rstN), .adjValid(adjValid), .adjScaledPpm(adjScaledPpm),
    .offsetValid(offsetValid), .offsetNs(offsetNs), .loadValid(loadValid),
    .loadNs(loadNs), .timeNs(timeA), .cycleCount(cycA));

  ns_time_counter #(.TICK_NS(10), .CYCLE_RESET(32'h0), .FOLD_INTERVAL(53)) u_dut10 (
    .clk(clk), .rstN(rstN), .adjValid(adjValid), .adjScaledPpm(adjScaledPpm),
    .offsetValid(offsetValid), .offsetNs(offsetNs), .loadValid(loadValid),
    .loadNs(loadNs), .timeNs(timeB), .cycleCount(cycB));

  typedef struct {
    string       tag;
    logic [63:0] tA;
    logic [31:0] cA;
    logic [63:0] tB;
    logic [31:0] cB;
  } expItem_t;

  expItem_t    expQ[$];
  expItem_t    mItem;
  int          nChecks = 0;
  int          nErrors = 0;
  bit          finished = 1'b0;

  // reference state, index 0 = 8 ns tick, 1 = 10 ns tick
  logic [91:0] acc [2];
  logic [31:0] mul [2];
  logic [31:0] pmul[2];
  logic [31:0] cyc [2];
  bit          pend = 1'b0;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refMult(int idx, int p);
    longint m, c, nom;
    m = p;
    if (m < 0) m = -m;
    if (m > 65536000) m = 65536000;
    if (idx == 0) begin c = m * 512 / 15625;  nom = 64'd8  << 28; end
    else          begin c = m * 128 / 3125;   nom = 64'd10 << 28; end
    return 32'((p < 0) ? nom - c : nom + c);
  endfunction

  task automatic drive(bit isLd, logic [63:0] ldv, bit isOf, logic [63:0] ofv,
                       bit isAd, int p, string tag);
    expItem_t e;
    @(negedge clk);
    loadValid = isLd; loadNs = ldv;
    offsetValid = isOf; offsetNs = ofv;
    adjValid = isAd; adjScaledPpm = p;
    for (int i = 0; i < 2; i++) begin
      if (pend) mul[i] = pmul[i];
      cyc[i] = cyc[i] + 32'd1;
      if (isLd)      acc[i] = {ldv, 28'd0};
      else if (isOf) acc[i] = acc[i] + 92'(mul[i]) + {ofv, 28'd0};
      else           acc[i] = acc[i] + 92'(mul[i]);
    end
    pend = 1'b0;
    if (isAd && !isLd && !isOf) begin
      for (int i = 0; i < 2; i++) pmul[i] = refMult(i, p);
      pend = 1'b1;
    end
    e.tag = tag;
    e.tA = acc[0][91:28]; e.cA = cyc[0];
    e.tB = acc[1][91:28]; e.cB = cyc[1];
    expQ.push_back(e);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) drive(1'b0, '0, 1'b0, '0, 1'b0, 0, tag);
  endtask

  // monitor: compare each edge's result 2 ns after that edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      mItem = expQ.pop_front();
      check(mItem.tag, "timeNs", timeA, mItem.tA);
      check("R2", "cycleCount", 64'(cycA), 64'(mItem.cA));
      check("R13", "timeNs(10ns)", timeB, mItem.tB);
      check("R13", "cycleCount(10ns)", 64'(cycB), 64'(mItem.cB));
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    acc[0] = '0; acc[1] = '0;
    mul[0] = 32'd8 << 28; mul[1] = 32'd10 << 28;
    pmul[0] = mul[0]; pmul[1] = mul[1];
    cyc[0] = RESET_A; cyc[1] = 32'h0;
    repeat (3) @(negedge clk);
    check("R1", "timeNs in reset", timeA, 64'd0);
    check("R1", "cycleCount in reset", 64'(cycA), 64'(RESET_A));
    check("R1", "timeNs(10ns) in reset", timeB, 64'd0);
    check("R1", "cycleCount(10ns) in reset", 64'(cycB), 64'd0);
    @(posedge clk);
    #1 rstN = 1'b1;

    idle(60, "R12");                                   // periodic folds
    idle(240, "R4");                                   // cycle counter wraps
    drive(1'b0, '0, 1'b0, '0, 1'b1, 65536000, "R5");   // max positive trim
    idle(400, "R3");                                   // fraction carries
    drive(1'b0, '0, 1'b0, '0, 1'b1, -123456, "R6");
    idle(60, "R6");
    drive(1'b0, '0, 1'b0, '0, 1'b1, 32'h7FFF_FFFF, "R7");
    idle(30, "R7");
    drive(1'b0, '0, 1'b0, '0, 1'b1, 32'h8000_0000, "R7");
    idle(30, "R7");
    drive(1'b0, '0, 1'b1, 64'd1000, 1'b0, 0, "R9");
    idle(5, "R9");
    drive(1'b0, '0, 1'b1, -64'sd5000, 1'b0, 0, "R9");
    idle(5, "R9");
    drive(1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, '0, 1'b0, 0, "R10");
    idle(10, "R10");
    drive(1'b1, 64'h0000_0000_1000_0000, 1'b1, 64'd999, 1'b1, 3000000, "R11");
    idle(5, "R11");
    drive(1'b0, '0, 1'b1, 64'd4242, 1'b1, -3000000, "R11");
    idle(5, "R11");
    drive(1'b0, '0, 1'b0, '0, 1'b1, 1000000, "R8");    // trim, then offset
    drive(1'b0, '0, 1'b1, 64'd777, 1'b0, 0, "R8");     // on the apply edge
    idle(20, "R8");
    drive(1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, '0, 1'b0, 0, "R10");
    idle(10, "R10");                                   // 64-bit wrap
    drive(1'b0, '0, 1'b0, '0, 1'b1, 0, "R5");          // back to nominal
    idle(50, "R5");
    repeat (3) @(posedge clk);
    #3;
    finished = 1'b1;
    summary();
  end
endmodule